// File: doc/BRIEF.md
# CAN Controller Freeze Sequencer

This block takes a CAN protocol controller into a debug freeze state and back out again. A freeze is requested by a halt control bit or by an active debug mode. The request is honoured only when the freeze-enable bit is set and the controller is not in a low-power mode. Before granting the freeze, the sequencer waits until the protocol engine reports a bus state where stopping is safe. It then waits until every internal buffer engine (arbitration, matching, move-in and move-out) has gone idle. Only after both conditions hold does it do the following: isolate the pins, stop the bit-time prescaler, allow writes to the error-counter register (read-only at all other times) and raise the acknowledge status bits.

When no request remains, the sequencer leaves the frozen state. All gating and status bits drop together, in the same cycle that the prescaler restarts. A request withdrawn while the sequencer is still waiting returns it to normal running without any acknowledge.

The block also checks the programmed bit timing. It computes the number of time quanta per bit from the three segment fields and flags a configuration error when the result is below the minimum. All pins are plain control and status signals. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure.

Top module: `can_freeze_seq`

## Requirements
- R1: A freeze request exists exactly when (halt_req or dbg_mode) is 1, frz_en is 1 and low_pwr is 0; without a request frz_ack never rises.
- R2: While requested, the sequencer leaves its bus wait only when proto_state is one of the safe codes 0 (idle), 3 (intermission), 4 (error-passive) or 5 (bus-off); codes 1, 2, 6 and 7 hold it waiting.
- R3: After the safe point is reached, frz_ack stays 0 while any bit of eng_busy is 1.
- R4: While frozen, rx_core is 1 regardless of rx_pin and tx_pin is 1 (recessive) regardless of tx_core; when not frozen, rx_core follows rx_pin and tx_pin follows tx_core combinationally.
- R5: presc_stop is 1 exactly while frozen.
- R6: A write (ecnt_wr_en with ecnt_wdata) updates ecnt_value on the next clock edge only while frozen; ecnt_wr_allow is 1 only while frozen; writes at other times are dropped and ecnt_value is unchanged.
- R7: On freeze entry, not_rdy and frz_ack rise together. With the request held and the safe state and idle engines already present, they are 1 after the third rising edge that samples the request, and 0 after the second.
- R8: When the request goes away while frozen, frz_ack, not_rdy, presc_stop and the pin gating all clear after the next rising edge.
- R9: A request withdrawn during either wait returns the sequencer to running without raising frz_ack; a later request again takes the full entry sequence of R7.
- R10: cfg_err is 1 exactly when 4 + prop_seg + pseg1 + pseg2 (the time quanta per bit, each field 3 bits) is below 8.
- R11: After reset, frz_ack, not_rdy, presc_stop and ecnt_wr_allow are 0 and ecnt_value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_req | input | 1 | Halt control bit |
| frz_en | input | 1 | Freeze-enable bit |
| dbg_mode | input | 1 | Debug-mode request |
| low_pwr | input | 1 | Controller is in a low-power mode |
| proto_state | input | 3 | Protocol state code (safe codes 0, 3, 4, 5) |
| eng_busy | input | 4 | Busy flags: arbitration, matching, move-in, move-out |
| rx_pin | input | 1 | Receive line from the bus |
| tx_core | input | 1 | Transmit value from the protocol engine |
| rx_core | output | 1 | Receive value delivered to the protocol engine |
| tx_pin | output | 1 | Transmit line to the bus |
| presc_stop | output | 1 | Stops the bit-time prescaler |
| ecnt_wr_en | input | 1 | Error-counter write strobe |
| ecnt_wdata | input | 16 | Error-counter write data |
| ecnt_value | output | 16 | Stored error-counter value |
| ecnt_wr_allow | output | 1 | Error-counter writes are accepted |
| prop_seg | input | 3 | Propagation segment field |
| pseg1 | input | 3 | Phase segment 1 field |
| pseg2 | input | 3 | Phase segment 2 field |
| cfg_err | output | 1 | Bit timing has too few time quanta |
| not_rdy | output | 1 | Not-ready status |
| frz_ack | output | 1 | Freeze acknowledge status |

## Verification
The assertions assume the inputs change only between clock edges and that reset is applied before the first checked edge. With that, the registered acknowledge can be related to the qualified request, the engine idle flag and the previous sequencer state without race. The bench drives every input on the falling clock edge and holds it for whole cycles. It withdraws requests only at points where the sequencer's expected state is known. It keeps the error-counter write strobe to single-cycle pulses, so each write pairs with exactly one expected update.

// File: rtl/fz_pkg.sv
package fz_pkg;
  typedef enum logic [1:0] {
    ST_RUN       = 2'd0,
    ST_WAIT_BUS  = 2'd1,
    ST_WAIT_IDLE = 2'd2,
    ST_FROZEN    = 2'd3
  } fz_state_e;

  localparam int PROTO_W = 3;
  localparam logic [PROTO_W-1:0] PS_IDLE     = 3'd0;
  localparam logic [PROTO_W-1:0] PS_INTERMIS = 3'd3;
  localparam logic [PROTO_W-1:0] PS_ERR_PASS = 3'd4;
  localparam logic [PROTO_W-1:0] PS_BUS_OFF  = 3'd5;

  function automatic logic proto_is_safe(input logic [PROTO_W-1:0] ps);
    return (ps == PS_IDLE) || (ps == PS_INTERMIS) ||
           (ps == PS_ERR_PASS) || (ps == PS_BUS_OFF);
  endfunction
endpackage

// File: rtl/fz_req_qual.sv
module fz_req_qual #(
  parameter int NUM_ENG = 4
) (
  input  logic                        halt_req,
  input  logic                        frz_en,
  input  logic                        dbg_mode,
  input  logic                        low_pwr,
  input  logic [fz_pkg::PROTO_W-1:0]  proto_state,
  input  logic [NUM_ENG-1:0]          eng_busy,
  output logic                        req,
  output logic                        bus_safe,
  output logic                        eng_idle
);
  logic [NUM_ENG:0] idle_chain;

  assign idle_chain[0] = 1'b1;
  for (genvar g = 0; g < NUM_ENG; g++) begin : g_idle
    assign idle_chain[g+1] = idle_chain[g] & ~eng_busy[g];
  end

  assign req      = (halt_req | dbg_mode) & frz_en & ~low_pwr;
  assign bus_safe = fz_pkg::proto_is_safe(proto_state);
  assign eng_idle = idle_chain[NUM_ENG];
endmodule

// File: rtl/fz_seq_fsm.sv
module fz_seq_fsm (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              bus_safe,
  input  logic              eng_idle,
  output fz_pkg::fz_state_e state,
  output logic              frozen
);
  import fz_pkg::*;

  fz_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RUN:       if (req) state_d = ST_WAIT_BUS;
      ST_WAIT_BUS:  if (!req) state_d = ST_RUN;
                    else if (bus_safe) state_d = ST_WAIT_IDLE;
      ST_WAIT_IDLE: if (!req) state_d = ST_RUN;
                    else if (eng_idle) state_d = ST_FROZEN;
      ST_FROZEN:    if (!req) state_d = ST_RUN;
      default:      state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_RUN;
    else        state_q <= state_d;
  end

  assign state  = state_q;
  assign frozen = (state_q == ST_FROZEN);
endmodule

// File: rtl/fz_err_cnt.sv
module fz_err_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frozen,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] value,
  output logic             wr_allow
);
  logic [CNT_W-1:0] value_q;

  assign wr_allow = frozen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 value_q <= '0;
    else if (wr_en && wr_allow) value_q <= wdata;
  end

  assign value = value_q;
endmodule

// File: rtl/fz_bt_check.sv
module fz_bt_check #(
  parameter int SEG_W  = 3,
  parameter int MIN_TQ = 8
) (
  input  logic [SEG_W-1:0] prop_seg,
  input  logic [SEG_W-1:0] pseg1,
  input  logic [SEG_W-1:0] pseg2,
  output logic             cfg_err
);
  localparam int TQ_W = SEG_W + 3;
  // sync quantum plus each field stored as length minus one
  localparam logic [TQ_W-1:0] FIXED_TQ = TQ_W'(4);

  logic [TQ_W-1:0] tq_per_bit;

  assign tq_per_bit = FIXED_TQ + TQ_W'(prop_seg) + TQ_W'(pseg1) + TQ_W'(pseg2);
  assign cfg_err    = (tq_per_bit < TQ_W'(MIN_TQ));
endmodule

// File: rtl/can_freeze_seq.sv
module can_freeze_seq #(
  parameter int NUM_ENG = 4,
  parameter int CNT_W   = 16,
  parameter int SEG_W   = 3,
  parameter int MIN_TQ  = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       halt_req,
  input  logic                       frz_en,
  input  logic                       dbg_mode,
  input  logic                       low_pwr,
  input  logic [fz_pkg::PROTO_W-1:0] proto_state,
  input  logic [NUM_ENG-1:0]         eng_busy,
  input  logic                       rx_pin,
  input  logic                       tx_core,
  output logic                       rx_core,
  output logic                       tx_pin,
  output logic                       presc_stop,
  input  logic                       ecnt_wr_en,
  input  logic [CNT_W-1:0]           ecnt_wdata,
  output logic [CNT_W-1:0]           ecnt_value,
  output logic                       ecnt_wr_allow,
  input  logic [SEG_W-1:0]           prop_seg,
  input  logic [SEG_W-1:0]           pseg1,
  input  logic [SEG_W-1:0]           pseg2,
  output logic                       cfg_err,
  output logic                       not_rdy,
  output logic                       frz_ack
);
  logic              req;
  logic              bus_safe;
  logic              eng_idle;
  logic              frozen;
  logic              in_wait_idle;
  fz_pkg::fz_state_e seq_state;

  fz_req_qual #(.NUM_ENG(NUM_ENG)) u_qual (
    .halt_req(halt_req), .frz_en(frz_en), .dbg_mode(dbg_mode),
    .low_pwr(low_pwr), .proto_state(proto_state), .eng_busy(eng_busy),
    .req(req), .bus_safe(bus_safe), .eng_idle(eng_idle)
  );

  fz_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req(req), .bus_safe(bus_safe),
    .eng_idle(eng_idle), .state(seq_state), .frozen(frozen)
  );

  fz_err_cnt #(.CNT_W(CNT_W)) u_ecnt (
    .clk(clk), .rst_n(rst_n), .frozen(frozen), .wr_en(ecnt_wr_en),
    .wdata(ecnt_wdata), .value(ecnt_value), .wr_allow(ecnt_wr_allow)
  );

  fz_bt_check #(.SEG_W(SEG_W), .MIN_TQ(MIN_TQ)) u_bt (
    .prop_seg(prop_seg), .pseg1(pseg1), .pseg2(pseg2), .cfg_err(cfg_err)
  );

  assign in_wait_idle = (seq_state == fz_pkg::ST_WAIT_IDLE);

  // pin isolation: both directions forced recessive while frozen
  assign rx_core    = frozen ? 1'b1 : rx_pin;
  assign tx_pin     = frozen ? 1'b1 : tx_core;
  assign presc_stop = frozen;
  assign not_rdy    = frozen;
  assign frz_ack    = frozen;
endmodule

// File: rtl/can_freeze_seq_chk.sv
module can_freeze_seq_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             eng_idle,
  input logic             in_wait_idle,
  input logic             frz_ack,
  input logic             not_rdy,
  input logic             presc_stop,
  input logic             rx_core,
  input logic             tx_pin,
  input logic             ecnt_wr_en,
  input logic [CNT_W-1:0] ecnt_value
);
  a_r1_no_ack_without_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frz_ack) |-> $past(req));

  a_r2_entry_from_wait_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frz_ack) |-> $past(in_wait_idle));

  a_r3_entry_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frz_ack) |-> $past(eng_idle));

  a_r4_pins_recessive: assert property (@(posedge clk) disable iff (!rst_n)
    frz_ack |-> (rx_core && tx_pin));

  a_r5_presc_tracks_ack: assert property (@(posedge clk) disable iff (!rst_n)
    presc_stop == frz_ack);

  a_r6_ecnt_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ecnt_value) |-> $past(ecnt_wr_en && frz_ack));

  a_r7_status_together: assert property (@(posedge clk) disable iff (!rst_n)
    not_rdy == frz_ack);

  a_r8_exit_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_ack && !req) |=> !frz_ack);
endmodule

bind can_freeze_seq can_freeze_seq_chk #(.CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .eng_idle(eng_idle),
  .in_wait_idle(in_wait_idle), .frz_ack(frz_ack), .not_rdy(not_rdy),
  .presc_stop(presc_stop), .rx_core(rx_core), .tx_pin(tx_pin),
  .ecnt_wr_en(ecnt_wr_en), .ecnt_value(ecnt_value)
);

// File: tb/can_freeze_seq_tb_top.sv
module can_freeze_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        halt_req = 0, frz_en = 0, dbg_mode = 0, low_pwr = 0;
  logic [2:0]  proto_state = 3'd0;
  logic [3:0]  eng_busy = 4'd0;
  logic        rx_pin = 1, tx_core = 1;
  logic        rx_core, tx_pin, presc_stop, ecnt_wr_allow, cfg_err, not_rdy, frz_ack;
  logic        ecnt_wr_en = 0;
  logic [15:0] ecnt_wdata = 16'd0;
  logic [15:0] ecnt_value;
  logic [2:0]  prop_seg = 3'd3, pseg1 = 3'd2, pseg2 = 3'd2;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  can_freeze_seq dut_i (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .frz_en(frz_en),
    .dbg_mode(dbg_mode), .low_pwr(low_pwr), .proto_state(proto_state),
    .eng_busy(eng_busy), .rx_pin(rx_pin), .tx_core(tx_core),
    .rx_core(rx_core), .tx_pin(tx_pin), .presc_stop(presc_stop),
    .ecnt_wr_en(ecnt_wr_en), .ecnt_wdata(ecnt_wdata), .ecnt_value(ecnt_value),
    .ecnt_wr_allow(ecnt_wr_allow), .prop_seg(prop_seg), .pseg1(pseg1),
    .pseg2(pseg2), .cfg_err(cfg_err), .not_rdy(not_rdy), .frz_ack(frz_ack)
  );

  typedef enum int {
    OB_ACK, OB_NRDY, OB_PRESC, OB_RX, OB_TX, OB_ECNT, OB_CFG, OB_WRA
  } obs_e;

  typedef struct {
    string       tag;
    obs_e        sel;
    logic [15:0] exp;
  } item_t;

  item_t exp_q[$];
  event  sample_ev;

  function automatic logic [15:0] observe(obs_e s);
    case (s)
      OB_ACK:   return {15'd0, frz_ack};
      OB_NRDY:  return {15'd0, not_rdy};
      OB_PRESC: return {15'd0, presc_stop};
      OB_RX:    return {15'd0, rx_core};
      OB_TX:    return {15'd0, tx_pin};
      OB_ECNT:  return ecnt_value;
      OB_CFG:   return {15'd0, cfg_err};
      default:  return {15'd0, ecnt_wr_allow};
    endcase
  endfunction

  // monitor: pops expected items and compares against the outputs
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it  = exp_q.pop_front();
        act = observe(it.sel);
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s obs=%0d actual=%0h expected=%0h", it.tag, it.sel, act, it.exp);
        end
      end
    end
  end

  task automatic push(string tag, obs_e sel, logic [15:0] e);
    item_t it;
    it.tag = tag; it.sel = sel; it.exp = e;
    exp_q.push_back(it);
  endtask

  task automatic sample();
    #0;
    ->sample_ev;
    wait (exp_q.size() == 0);
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_frozen(string tag, logic f);
    push(tag, OB_ACK, {15'd0, f});
    push(tag, OB_NRDY, {15'd0, f});
    push(tag, OB_PRESC, {15'd0, f});
    push(tag, OB_WRA, {15'd0, f});
    sample();
  endtask

  task automatic release_all();
    halt_req = 0; dbg_mode = 0; frz_en = 0; low_pwr = 0;
    proto_state = 3'd0; eng_busy = 4'd0;
    cyc(2);
  endtask

  task automatic bt_case(logic [2:0] p, logic [2:0] a, logic [2:0] b, logic e);
    prop_seg = p; pseg1 = a; pseg2 = b;
    #1;
    push("R10 time quanta check", OB_CFG, {15'd0, e});
    sample();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R11 reset state
    expect_frozen("R11 reset", 1'b0);
    push("R11 reset ecnt", OB_ECNT, 16'd0);
    sample();

    // R1: no freeze-enable, or low power, blocks the request
    halt_req = 1; frz_en = 0;
    cyc(6);
    expect_frozen("R1 enable clear", 1'b0);
    frz_en = 1; low_pwr = 1;
    cyc(6);
    expect_frozen("R1 low power", 1'b0);
    release_all();

    // R6: write outside frozen is dropped
    ecnt_wdata = 16'h00A5; ecnt_wr_en = 1;
    cyc(1);
    ecnt_wr_en = 0;
    cyc(1);
    push("R6 write dropped", OB_ECNT, 16'd0);
    sample();

    // R4 pass-through when running
    rx_pin = 0; tx_core = 0;
    #1;
    push("R4 rx pass", OB_RX, 16'd0);
    push("R4 tx pass", OB_TX, 16'd0);
    sample();

    // R7 entry timing via debug mode, conditions already met
    dbg_mode = 1; frz_en = 1;
    cyc(2);
    expect_frozen("R7 not before third edge", 1'b0);
    cyc(1);
    expect_frozen("R7 ack on third edge", 1'b1);

    // R4 isolation while frozen
    push("R4 rx forced", OB_RX, 16'd1);
    push("R4 tx recessive", OB_TX, 16'd1);
    sample();

    // R6 write accepted while frozen
    ecnt_wdata = 16'h1234; ecnt_wr_en = 1;
    cyc(1);
    ecnt_wr_en = 0;
    push("R6 write accepted", OB_ECNT, 16'h1234);
    sample();

    // R8 exit when freeze-enable clears
    frz_en = 0;
    cyc(1);
    expect_frozen("R8 exit", 1'b0);
    push("R8 rx released", OB_RX, 16'd0);
    push("R8 tx released", OB_TX, 16'd0);
    sample();
    ecnt_wdata = 16'hBEEF; ecnt_wr_en = 1;
    cyc(1);
    ecnt_wr_en = 0;
    push("R6 value kept after exit", OB_ECNT, 16'h1234);
    sample();
    release_all();

    // R2 unsafe bus state holds the wait
    proto_state = 3'd1; halt_req = 1; frz_en = 1;
    cyc(6);
    expect_frozen("R2 transmit unsafe", 1'b0);
    proto_state = 3'd6;
    cyc(4);
    expect_frozen("R2 error frame unsafe", 1'b0);
    proto_state = 3'd3;
    cyc(1);
    expect_frozen("R2 one edge after safe", 1'b0);
    cyc(1);
    expect_frozen("R2 ack after intermission", 1'b1);
    release_all();

    // R3 busy engines hold the wait
    eng_busy = 4'b0100; proto_state = 3'd5; halt_req = 1; frz_en = 1;
    cyc(6);
    expect_frozen("R3 move-in busy", 1'b0);
    eng_busy = 4'b1000;
    cyc(3);
    expect_frozen("R3 move-out busy", 1'b0);
    eng_busy = 4'b0000;
    cyc(1);
    expect_frozen("R3 ack after idle", 1'b1);
    // R8 exit when halt clears
    halt_req = 0;
    cyc(1);
    expect_frozen("R8 halt cleared", 1'b0);
    release_all();

    // R9 withdraw during bus wait, then full sequence again
    proto_state = 3'd2; halt_req = 1; frz_en = 1;
    cyc(3);
    halt_req = 0;
    cyc(1);
    proto_state = 3'd4;
    cyc(3);
    expect_frozen("R9 withdrawn no ack", 1'b0);
    halt_req = 1;
    cyc(2);
    expect_frozen("R9 restart not early", 1'b0);
    cyc(1);
    expect_frozen("R9 restart acks", 1'b1);
    release_all();

    // R9 withdraw during idle wait
    eng_busy = 4'b0001; halt_req = 1; frz_en = 1;
    cyc(4);
    frz_en = 0;
    cyc(1);
    eng_busy = 4'b0000;
    cyc(3);
    expect_frozen("R9 withdrawn in idle wait", 1'b0);
    release_all();

    // R10 bit timing
    bt_case(3'd0, 3'd0, 3'd0, 1'b1);
    bt_case(3'd1, 3'd1, 3'd1, 1'b1);
    bt_case(3'd2, 3'd1, 3'd1, 1'b0);
    bt_case(3'd0, 3'd0, 3'd4, 1'b0);
    bt_case(3'd7, 3'd7, 3'd7, 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule